// File: doc/BRIEF.md
# UART Transmit Queue Service Logic

This block owns the transmit queue of a UART and decides when that queue asks for more data. Software or a DMA engine writes bytes through a holding-register write strobe. A serializer takes bytes out through a valid/take handshake and reports whether its shift stage still holds a byte. Three service paths look at the same fill level, each with its own threshold:

- an interrupt line that latches when the queue is at least half empty;
- polled status bits for "needs data" and "fully drained";
- a DMA request that stays high while the queue is strictly less than half full.

With the queue enabled, it holds `DEPTH` entries. With the queue disabled, it behaves as a single holding register. A write that finds no room is dropped and sets a sticky overflow flag. The DMA threshold keeps more than half the queue free whenever a request is raised, so a burst of 8, 16 or 32 bytes always fits with the default depth. Bit timing, baud generation and the DMA engine are outside this block.

Top module: `uart_txq_service`

## Requirements
- R1: `tx_irq` is high only if both `fifo_en` and `txi_en` were high in the previous cycle.
- R2: While both enables are high, `tx_irq` rises one cycle after the fill level becomes less than or equal to DEPTH/2 (the queue is at least half empty).
- R3: A cycle with `hold_wr` or `iid_rd` high clears `tx_irq` on the next cycle. If the half-empty condition persists, `tx_irq` stays low. It asserts again only after the level has gone above DEPTH/2 and then returned to DEPTH/2 or below, or after an enable has dropped and returned.
- R4: In queue mode, `st_tdrq` equals (level <= DEPTH/2). In single-register mode, `st_tdrq` equals (level == 0).
- R5: `st_temt` is high exactly when the level is 0 and `ser_busy` is low.
- R6: `dma_req` equals `fifo_en && dma_en && level < DEPTH/2`. It is never high in single-register mode.
- R7: With `txi_en` and `dma_en` both low, `tx_irq` and `dma_req` stay low, and `st_tdrq` and `st_temt` keep reporting.
- R8: Capacity is DEPTH entries when `fifo_en` is high and 1 entry when it is low. A write when full is dropped and sets `ovf_flag`, which stays set until reset.
- R9: `ser_data` presents the oldest stored byte while `ser_valid` is high. A cycle with `ser_take` high removes it, so bytes leave in write order.
- R10: Any change of `fifo_en` discards every stored byte on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue mode enable (low: single holding register) |
| txi_en | input | 1 | Transmit interrupt enable |
| dma_en | input | 1 | Transmit DMA request enable |
| hold_wr | input | 1 | Holding-register write strobe |
| hold_data | input | DATA_W | Byte written with `hold_wr` |
| iid_rd | input | 1 | Interrupt-identification read strobe |
| ser_take | input | 1 | Serializer takes the presented byte |
| ser_busy | input | 1 | Serializer shift stage holds a byte |
| ser_valid | output | 1 | A byte is available to the serializer |
| ser_data | output | DATA_W | Oldest stored byte |
| tx_irq | output | 1 | Transmit data interrupt |
| st_tdrq | output | 1 | Status: transmitter needs data |
| st_temt | output | 1 | Status: queue and shift stage empty |
| dma_req | output | 1 | Transmit DMA request |
| ovf_flag | output | 1 | Sticky write-overflow flag |

## Verification
The interrupt-clear property assumes that a pop cannot raise a fresh threshold crossing in the same cycle as a clear while the interrupt is already high. This holds because a high interrupt means the condition already held one cycle earlier. The take-side properties assume that `ser_take` is only meaningful while `ser_valid` is high. The stimulus drives `ser_take` only when a byte is presented and changes every input away from the clock edge. It also keeps `ser_busy` low except during the dedicated drain-status check.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  typedef struct packed {
    logic need_data;
    logic drained;
    logic dma;
    logic irq_cond;
  } txq_flags_t;
endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fifo_mode,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CW-1:0]     level,
  output logic              drop
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CW-1:0] level_d, cap;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cap     = fifo_mode ? CW'(DEPTH) : CW'(1);
    full    = (level >= cap);
    do_push = push_req && !full && !flush;
    do_pop  = pop_req && (level != '0) && !flush;
    drop    = push_req && full && !flush;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    level_d  = level;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = bump(wr_ptr);
      if (do_pop)  rd_ptr_d = bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level_d = level + CW'(1);
        2'b01:   level_d = level - CW'(1);
        default: level_d = level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      level  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
endmodule

// File: rtl/uart_txq_status.sv
module uart_txq_status
  import uart_txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          fifo_mode,
  input  logic          irq_en,
  input  logic          dma_en,
  input  logic          shift_busy,
  input  logic [CW-1:0] level,
  output txq_flags_t    flags
);
  logic half_free, below_half, empty;

  always_comb begin
    empty      = (level == '0);
    half_free  = (level <= CW'(HALF));
    below_half = (level <  CW'(HALF));
    flags.need_data = fifo_mode ? half_free : empty;
    flags.drained   = empty && !shift_busy;
    flags.dma       = fifo_mode && dma_en && below_half;
    flags.irq_cond  = fifo_mode && irq_en && half_free;
  end
endmodule

// File: rtl/uart_txq_irq.sv
module uart_txq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clear,
  output logic irq
);
  logic cond_q, irq_q, irq_d, rise;

  always_comb begin
    rise  = cond && !cond_q;
    irq_d = cond && (rise || (irq_q && !clear));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/uart_txq_service.sv
module uart_txq_service
  import uart_txq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              txi_en,
  input  logic              dma_en,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              iid_rd,
  input  logic              ser_take,
  input  logic              ser_busy,
  output logic              ser_valid,
  output logic [DATA_W-1:0] ser_data,
  output logic              tx_irq,
  output logic              st_tdrq,
  output logic              st_temt,
  output logic              dma_req,
  output logic              ovf_flag
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          mode_q, flush, drop, ovf_q, ovf_d;
  logic [CW-1:0] level;
  txq_flags_t    flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    flush = (fifo_en != mode_q);
    ovf_d = ovf_q || drop;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (drop) ovf_q <= ovf_d;
    end
  end

  uart_txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_int_n), .flush(flush), .fifo_mode(fifo_en),
    .push_req(hold_wr), .push_data(hold_data), .pop_req(ser_take),
    .out_valid(ser_valid), .out_data(ser_data), .level(level), .drop(drop)
  );

  uart_txq_status #(.DEPTH(DEPTH)) status_i (
    .fifo_mode(fifo_en), .irq_en(txi_en), .dma_en(dma_en),
    .shift_busy(ser_busy), .level(level), .flags(flags)
  );

  uart_txq_irq irq_i (
    .clk(clk), .rst_n(rst_int_n), .cond(flags.irq_cond),
    .clear(hold_wr || iid_rd), .irq(tx_irq)
  );

  assign st_tdrq  = flags.need_data;
  assign st_temt  = flags.drained;
  assign dma_req  = flags.dma;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/uart_txq_service_chk.sv
module uart_txq_service_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_en,
  input logic txi_en,
  input logic dma_en,
  input logic hold_wr,
  input logic iid_rd,
  input logic ser_busy,
  input logic ser_valid,
  input logic tx_irq,
  input logic st_tdrq,
  input logic st_temt,
  input logic dma_req,
  input logic ovf_flag
);
  assert_irq_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(fifo_en && txi_en));

  assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && (hold_wr || iid_rd)) |=> !tx_irq);

  assert_temt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_temt |-> (!ser_valid && !ser_busy));

  assert_dma_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (fifo_en && dma_en && st_tdrq));

  assert_polled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!txi_en && !dma_en) |-> !dma_req);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid && !hold_wr) |=> !ser_valid);
endmodule

bind uart_txq_service uart_txq_service_chk chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .txi_en(txi_en),
  .dma_en(dma_en), .hold_wr(hold_wr), .iid_rd(iid_rd), .ser_busy(ser_busy),
  .ser_valid(ser_valid), .tx_irq(tx_irq), .st_tdrq(st_tdrq),
  .st_temt(st_temt), .dma_req(dma_req), .ovf_flag(ovf_flag)
);

// File: tb/uart_txq_service_tb_top.sv
`timescale 1ns/1ps
module uart_txq_service_tb_top;
  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;

  logic clk, rst_n, fifo_en, txi_en, dma_en, hold_wr, iid_rd, ser_take, ser_busy;
  logic [7:0] hold_data, ser_data;
  logic ser_valid, tx_irq, st_tdrq, st_temt, dma_req, ovf_flag;
  int total, bad;
  bit done;

  uart_txq_service #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .txi_en(txi_en),
    .dma_en(dma_en), .hold_wr(hold_wr), .hold_data(hold_data),
    .iid_rd(iid_rd), .ser_take(ser_take), .ser_busy(ser_busy),
    .ser_valid(ser_valid), .ser_data(ser_data), .tx_irq(tx_irq),
    .st_tdrq(st_tdrq), .st_temt(st_temt), .dma_req(dma_req),
    .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] d);
    hold_wr = 1'b1; hold_data = d;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  task automatic do_pop();
    ser_take = 1'b1;
    @(negedge clk);
    ser_take = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 0; fifo_en = 0; txi_en = 0; dma_en = 0; hold_wr = 0;
    hold_data = 0; iid_rd = 0; ser_take = 0; ser_busy = 0;
    step(4); rst_n = 1; step(3);
    chk("R9 reset valid", ser_valid, 0);
    chk("R5 reset temt", st_temt, 1);
    chk("R1 reset irq", tx_irq, 0);
    chk("R6 reset dma", dma_req, 0);
    chk("R8 reset ovf", ovf_flag, 0);
    chk("R4 reset tdrq", st_tdrq, 1);

    fifo_en = 1; step(2);
    txi_en = 1; step(2);
    chk("R2 irq on enable", tx_irq, 1);
    chk("R6 dma off", dma_req, 0);
    dma_en = 1; step(1);
    chk("R6 dma on empty", dma_req, 1);
    iid_rd = 1; step(1); iid_rd = 0;
    chk("R3 irq cleared by read", tx_irq, 0);
    step(3);
    chk("R3 irq stays low", tx_irq, 0);

    for (int i = 0; i < DEPTH; i++) begin
      do_wr(8'(i * 3 + 1));
      chk("R4 fill tdrq", st_tdrq, int'((i + 1) <= HALF));
      chk("R6 fill dma", dma_req, int'((i + 1) < HALF));
      chk("R5 fill temt", st_temt, 0);
      chk("R3 fill irq", tx_irq, 0);
      chk("R8 fill ovf", ovf_flag, 0);
    end
    do_wr(8'hEE);
    chk("R8 overflow flag", ovf_flag, 1);
    step(2);
    chk("R8 overflow sticky", ovf_flag, 1);

    for (int k = 0; k < DEPTH; k++) begin
      chk("R9 order", ser_data, (k * 3 + 1) % 256);
      chk("R9 valid", ser_valid, 1);
      do_pop();
      chk("R4 drain tdrq", st_tdrq, int'((DEPTH - 1 - k) <= HALF));
      chk("R6 drain dma", dma_req, int'((DEPTH - 1 - k) < HALF));
      if (DEPTH - 1 - k == HALF) begin
        step(1);
        chk("R3 irq re-asserts on crossing", tx_irq, 1);
      end
    end
    chk("R9 drained valid", ser_valid, 0);
    chk("R5 drained temt", st_temt, 1);
    ser_busy = 1; step(1);
    chk("R5 shift busy temt", st_temt, 0);
    ser_busy = 0; step(1);

    do_wr(8'hA5);
    chk("R3 irq cleared by write", tx_irq, 0);
    chk("R9 write value", ser_data, 8'hA5);
    do_pop(); step(2);
    chk("R3 no re-assert without crossing", tx_irq, 0);

    txi_en = 0; step(2);
    chk("R1 irq off without txi_en", tx_irq, 0);
    txi_en = 1; step(2);
    chk("R2 irq on re-enable", tx_irq, 1);
    fifo_en = 0; step(2);
    chk("R1 irq off without fifo_en", tx_irq, 0);
    chk("R6 dma off in single mode", dma_req, 0);

    do_wr(8'h11); do_wr(8'h22);
    chk("R4 single tdrq", st_tdrq, 0);
    chk("R5 single temt", st_temt, 0);
    chk("R8 single keeps first", ser_data, 8'h11);
    do_pop();
    chk("R8 single second dropped", ser_valid, 0);
    chk("R4 single tdrq empty", st_tdrq, 1);

    do_wr(8'h33);
    chk("R10 pre-flush valid", ser_valid, 1);
    fifo_en = 1; step(2);
    chk("R10 flushed valid", ser_valid, 0);
    chk("R10 flushed temt", st_temt, 1);

    txi_en = 0; dma_en = 0; step(1);
    do_wr(8'h01); do_wr(8'h02); do_wr(8'h03);
    step(2);
    chk("R7 polled irq", tx_irq, 0);
    chk("R7 polled dma", dma_req, 0);
    chk("R7 polled tdrq", st_tdrq, 1);
    chk("R7 polled temt", st_temt, 0);
    for (int j = 0; j < 3; j++) begin
      chk("R7 polled order", ser_data, j + 1);
      do_pop();
    end
    chk("R7 polled temt drained", st_temt, 1);
    chk("R8 ovf survives flush", ovf_flag, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule